// File: doc/BRIEF.md
# Dot-Matrix Segment Output Selector

This block builds the anode pattern for one digit position of a scanned 5x7 dot-matrix vacuum fluorescent display. When the scan logic announces a new digit slot, it reads that digit's 8-bit character code and its 4-bit symbol word from two per-digit memories. The character code then selects a 35-bit dot pattern. Codes below 16 read a writable user glyph memory, and all higher codes read a fixed character ROM.

The 35 dot bits drive the segment anodes. The symbol word bypasses glyph lookup and drives four auxiliary anodes directly. Before the 39 outputs leave the block, a lamp-test mode register and a per-slot blanking input are applied to them. All outputs are registered, and they hold one digit's pattern for the whole slot.

Top module: `vfd_anode_select`

## Requirements
- R1: After reset, every segment and auxiliary output is low, and the lamp mode is forced-dark. Scanning a digit without first writing the mode leaves the outputs low.
- R2: A character code from 0x00 to 0x0F selects the user glyph memory entry with the same index.
- R3: A character code from 0x10 to 0xFF selects the ROM. With ROM_STUB=0, the ROM pattern for code c is {c[2:0], c, c, c, c}, with the most significant bit on the left.
- R4: Pattern bit n drives seg_o[n] (segment n+1). Bits are laid out row by row, five per row, so bit 0 is the top-left dot and bit 34 is the bottom-right dot.
- R5: aux_o[k] equals bit k of the symbol word stored for the scanned digit, with no glyph lookup.
- R6: Digit index d reads entry d of the code memory and entry d of the symbol memory. Writes to addresses at or above DIGITS are dropped and do not alias onto any stored entry.
- R7: With mode_dark set and mode_lit clear, every segment and auxiliary output is low.
- R8: With mode_lit set, every segment and auxiliary output is high, whatever the value of mode_dark.
- R9: With both mode bits clear, the outputs show the selected pattern and symbol.
- R10: While blank_i is high, every segment and auxiliary output is driven low on the next edge. This overrides lamp-lit mode.
- R11: The outputs take the new digit's data on the third rising edge after the edge that samples slot_start_i. They keep that data until the next slot, even if the memories are written in between.
- R12: A mode write (mode_we_i) reaches the outputs on the second rising edge after it is sampled. Without a write, the mode holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_we_i | input | 1 | Code memory write enable |
| code_waddr_i | input | 5 | Code memory write address |
| code_wdata_i | input | 8 | Character code to store |
| glyph_we_i | input | 1 | User glyph memory write enable |
| glyph_waddr_i | input | 4 | User glyph write address |
| glyph_wdata_i | input | 35 | 35-bit dot pattern to store |
| sym_we_i | input | 1 | Symbol memory write enable |
| sym_waddr_i | input | 5 | Symbol memory write address |
| sym_wdata_i | input | 4 | Symbol word to store |
| mode_we_i | input | 1 | Lamp mode register write enable |
| mode_lit_i | input | 1 | Lamp-lit bit to write (all outputs high) |
| mode_dark_i | input | 1 | Forced-dark bit to write (all outputs low) |
| slot_start_i | input | 1 | One-cycle pulse that opens a digit slot |
| digit_i | input | 5 | Index of the digit being scanned, sampled with slot_start_i |
| blank_i | input | 1 | Blank interval of the current slot |
| seg_o | output | 35 | Segment anode drive |
| aux_o | output | 4 | Auxiliary anode drive |

## Verification
The bench builds the block with its defaults: 24 digits, 16 user glyphs and the computed ROM (ROM_STUB=0). Because the ROM content can be predicted, codes 0x10 and 0xFF can be checked at the exact boundary of the code split, alongside codes 0x03 and 0x0F on the user side. At 24 digits, address 24 is the first address past the memory, so the bench writes there and confirms that nothing aliases onto entry 0. Single-hot glyphs at bits 0 and 34 pin down both ends of the segment ordering.

// File: rtl/vfd_sel_pkg.sv
package vfd_sel_pkg;
  localparam int COLS   = 5;
  localparam int ROWS   = 7;
  localparam int SEG_W  = COLS * ROWS;
  localparam int CODE_W = 8;
  localparam int SYM_W  = 4;

  // Computed ROM used in place of real glyph art.
  function automatic logic [SEG_W-1:0] rom_glyph(input logic [CODE_W-1:0] c);
    return {c[2:0], c, c, c, c};
  endfunction
endpackage

// File: rtl/vfd_sync_ram.sv
module vfd_sync_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 24,
  parameter int AW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (32'(waddr_i) < DEPTH)) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (re_i)   rdata_o <= (32'(raddr_i) < DEPTH) ? mem_q[raddr_i] : '0;
  end
endmodule

// File: rtl/vfd_out_stage.sv
module vfd_out_stage #(
  parameter int SEG_W = 35,
  parameter int SYM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEG_W-1:0] seg_new_i,
  input  logic [SYM_W-1:0] sym_new_i,
  input  logic             lit_i,
  input  logic             dark_i,
  input  logic             blank_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [SYM_W-1:0] aux_o
);
  logic [SEG_W-1:0] seg_hold_q, seg_nxt;
  logic [SYM_W-1:0] sym_hold_q, sym_nxt;

  assign seg_nxt = load_i ? seg_new_i : seg_hold_q;
  assign sym_nxt = load_i ? sym_new_i : sym_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_hold_q <= '0;
      sym_hold_q <= '0;
      seg_o      <= '0;
      aux_o      <= '0;
    end else begin
      seg_hold_q <= seg_nxt;
      sym_hold_q <= sym_nxt;
      // priority: blank > lit > dark > data
      if (blank_i) begin
        seg_o <= '0;
        aux_o <= '0;
      end else if (lit_i) begin
        seg_o <= '1;
        aux_o <= '1;
      end else if (dark_i) begin
        seg_o <= '0;
        aux_o <= '0;
      end else begin
        seg_o <= seg_nxt;
        aux_o <= sym_nxt;
      end
    end
  end

  p_blank_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> (seg_o == '0 && aux_o == '0));
  p_lit_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lit_i && !blank_i) |=> (&seg_o && &aux_o));
  p_dark_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dark_i && !lit_i && !blank_i) |=> (seg_o == '0 && aux_o == '0));
  p_aux_direct_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !lit_i && !dark_i && !blank_i) |=> (aux_o == $past(sym_new_i)));
endmodule

// File: rtl/vfd_anode_select.sv
module vfd_anode_select
  import vfd_sel_pkg::*;
#(
  parameter int DIGITS   = 24,
  parameter int GLYPHS   = 16,
  parameter int ROM_STUB = 0,
  localparam int DAW     = $clog2(DIGITS),
  localparam int GAW     = $clog2(GLYPHS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_we_i,
  input  logic [DAW-1:0]    code_waddr_i,
  input  logic [CODE_W-1:0] code_wdata_i,
  input  logic              glyph_we_i,
  input  logic [GAW-1:0]    glyph_waddr_i,
  input  logic [SEG_W-1:0]  glyph_wdata_i,
  input  logic              sym_we_i,
  input  logic [DAW-1:0]    sym_waddr_i,
  input  logic [SYM_W-1:0]  sym_wdata_i,
  input  logic              mode_we_i,
  input  logic              mode_lit_i,
  input  logic              mode_dark_i,
  input  logic              slot_start_i,
  input  logic [DAW-1:0]    digit_i,
  input  logic              blank_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic [SYM_W-1:0]  aux_o
);
  logic              v1_q, v2_q;
  logic [CODE_W-1:0] code_rd;
  logic [SYM_W-1:0]  sym_rd, sym2_q;
  logic [SEG_W-1:0]  glyph_rd, rom_pat, rom_q, pat_sel;
  logic              user_q;
  logic              lit_q, dark_q;

  vfd_sync_ram #(.W(CODE_W), .DEPTH(DIGITS), .AW(DAW)) u_code_ram (
    .clk_i, .rst_ni,
    .we_i(code_we_i), .waddr_i(code_waddr_i), .wdata_i(code_wdata_i),
    .re_i(slot_start_i), .raddr_i(digit_i), .rdata_o(code_rd));

  vfd_sync_ram #(.W(SYM_W), .DEPTH(DIGITS), .AW(DAW)) u_sym_ram (
    .clk_i, .rst_ni,
    .we_i(sym_we_i), .waddr_i(sym_waddr_i), .wdata_i(sym_wdata_i),
    .re_i(slot_start_i), .raddr_i(digit_i), .rdata_o(sym_rd));

  vfd_sync_ram #(.W(SEG_W), .DEPTH(GLYPHS), .AW(GAW)) u_glyph_ram (
    .clk_i, .rst_ni,
    .we_i(glyph_we_i), .waddr_i(glyph_waddr_i), .wdata_i(glyph_wdata_i),
    .re_i(v1_q), .raddr_i(code_rd[GAW-1:0]), .rdata_o(glyph_rd));

  generate
    if (ROM_STUB != 0) begin : g_rom_stub
      assign rom_pat = '0;
    end else begin : g_rom_calc
      assign rom_pat = rom_glyph(code_rd);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      rom_q  <= '0;
      user_q <= 1'b0;
      sym2_q <= '0;
      lit_q  <= 1'b0;
      dark_q <= 1'b1;
    end else begin
      v1_q <= slot_start_i;
      v2_q <= v1_q;
      if (v1_q) begin
        rom_q  <= rom_pat;
        user_q <= (32'(code_rd) < GLYPHS);
        sym2_q <= sym_rd;
      end
      if (mode_we_i) begin
        lit_q  <= mode_lit_i;
        dark_q <= mode_dark_i;
      end
    end
  end

  assign pat_sel = user_q ? glyph_rd : rom_q;

  vfd_out_stage #(.SEG_W(SEG_W), .SYM_W(SYM_W)) u_out (
    .clk_i, .rst_ni,
    .load_i(v2_q), .seg_new_i(pat_sel), .sym_new_i(sym2_q),
    .lit_i(lit_q), .dark_i(dark_q), .blank_i(blank_i),
    .seg_o(seg_o), .aux_o(aux_o));

  p_mode_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable({lit_q, dark_q}));
  p_mode_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (lit_q == $past(mode_lit_i) && dark_q == $past(mode_dark_i)));
endmodule

// File: tb/vfd_anode_select_tb.sv
module vfd_anode_select_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        code_we_i = 0, glyph_we_i = 0, sym_we_i = 0, mode_we_i = 0;
  logic [4:0]  code_waddr_i = 0, sym_waddr_i = 0, digit_i = 0;
  logic [7:0]  code_wdata_i = 0;
  logic [3:0]  glyph_waddr_i = 0, sym_wdata_i = 0;
  logic [34:0] glyph_wdata_i = 0;
  logic        mode_lit_i = 0, mode_dark_i = 0, slot_start_i = 0, blank_i = 0;
  logic [34:0] seg_o;
  logic [3:0]  aux_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  vfd_anode_select u_dut (.*);

  function automatic logic [34:0] rom_exp(input logic [7:0] c);
    return {c[2:0], c, c, c, c};
  endfunction

  task automatic chk(input string req, input logic [34:0] s_exp, input logic [3:0] a_exp);
    n_run++;
    if (seg_o !== s_exp || aux_o !== a_exp) begin
      n_fail++;
      $display("FAIL %s: seg=%h aux=%h expected seg=%h aux=%h", req, seg_o, aux_o, s_exp, a_exp);
    end
  endtask

  task automatic wr_code(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i); code_we_i = 1; code_waddr_i = a; code_wdata_i = d;
    @(negedge clk_i); code_we_i = 0;
  endtask
  task automatic wr_glyph(input logic [3:0] a, input logic [34:0] d);
    @(negedge clk_i); glyph_we_i = 1; glyph_waddr_i = a; glyph_wdata_i = d;
    @(negedge clk_i); glyph_we_i = 0;
  endtask
  task automatic wr_sym(input logic [4:0] a, input logic [3:0] d);
    @(negedge clk_i); sym_we_i = 1; sym_waddr_i = a; sym_wdata_i = d;
    @(negedge clk_i); sym_we_i = 0;
  endtask
  task automatic set_mode(input logic lit, input logic dark);
    @(negedge clk_i); mode_we_i = 1; mode_lit_i = lit; mode_dark_i = dark;
    @(negedge clk_i); mode_we_i = 0;   // one edge sampled
    @(negedge clk_i);                   // second edge: outputs updated
  endtask
  // Scan one digit and return at the negedge after the third edge.
  task automatic scan(input logic [4:0] d);
    @(negedge clk_i); slot_start_i = 1; digit_i = d;
    @(negedge clk_i); slot_start_i = 0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R1 reset", '0, '0);
    wr_glyph(4'd0, '1); wr_code(5'd0, 8'h00); wr_sym(5'd0, 4'hF);
    scan(5'd0);
    chk("R1 default dark", '0, '0);
  endtask

  task automatic t_user_glyph;
    set_mode(0, 0);
    wr_glyph(4'd3, 35'h1); wr_code(5'd2, 8'h03); wr_sym(5'd2, 4'h0);
    scan(5'd2);
    chk("R2 R4 R9 code 03 bit0", 35'h1, 4'h0);
    wr_glyph(4'd15, 35'h4_0000_0000); wr_code(5'd7, 8'h0F); wr_sym(5'd7, 4'h0);
    scan(5'd7);
    chk("R2 R4 code 0F bit34", 35'h4_0000_0000, 4'h0);
  endtask

  task automatic t_rom;
    wr_code(5'd23, 8'h10); wr_sym(5'd23, 4'h0);
    scan(5'd23);
    chk("R3 code 10", rom_exp(8'h10), 4'h0);
    wr_code(5'd23, 8'hFF);
    scan(5'd23);
    chk("R3 code FF", rom_exp(8'hFF), 4'h0);
  endtask

  task automatic t_sym;
    wr_code(5'd4, 8'h41); wr_sym(5'd4, 4'b1001);
    scan(5'd4);
    chk("R5 aux direct", rom_exp(8'h41), 4'b1001);
  endtask

  task automatic t_oob;
    wr_glyph(4'd5, 35'h5_5555_5555); wr_code(5'd0, 8'h05); wr_sym(5'd0, 4'h6);
    wr_code(5'd24, 8'h20); wr_sym(5'd24, 4'h1);
    scan(5'd0);
    chk("R6 no alias addr 24", 35'h5_5555_5555, 4'h6);
  endtask

  task automatic t_latency;
    wr_code(5'd9, 8'h0A); wr_glyph(4'd10, 35'h0_F0F0_F0F0); wr_sym(5'd9, 4'h3);
    scan(5'd0);
    @(negedge clk_i); slot_start_i = 1; digit_i = 5'd9;
    @(negedge clk_i); slot_start_i = 0;
    @(negedge clk_i);
    chk("R11 old data after 2 edges", 35'h5_5555_5555, 4'h6);
    @(negedge clk_i);
    chk("R11 new data at 3rd edge", 35'h0_F0F0_F0F0, 4'h3);
    wr_code(5'd9, 8'h77); wr_glyph(4'd10, 35'h0); wr_sym(5'd9, 4'h0);
    repeat (3) @(negedge clk_i);
    chk("R11 held within slot", 35'h0_F0F0_F0F0, 4'h3);
  endtask

  task automatic t_modes;
    set_mode(0, 1);
    chk("R7 dark", '0, '0);
    set_mode(1, 0);
    chk("R8 lit", '1, '1);
    set_mode(1, 1);
    chk("R8 lit beats dark", '1, '1);
    @(negedge clk_i); mode_we_i = 1; mode_lit_i = 0; mode_dark_i = 0;
    @(negedge clk_i); mode_we_i = 0;
    chk("R12 one edge: not yet", '1, '1);
    @(negedge clk_i);
    chk("R12 R9 data back", 35'h0_F0F0_F0F0, 4'h3);
  endtask

  task automatic t_blank;
    @(negedge clk_i); blank_i = 1;
    @(negedge clk_i);
    chk("R10 blank data", '0, '0);
    set_mode(1, 0);
    chk("R10 blank beats lit", '0, '0);
    @(negedge clk_i); blank_i = 0;
    @(negedge clk_i);
    chk("R10 release shows lit", '1, '1);
    set_mode(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_user_glyph();
    t_rom();
    t_sym();
    t_oob();
    t_latency();
    t_modes();
    t_blank();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule